// File: doc/BRIEF.md
# Three-Tap Concurrent FIR Filter

This block filters a stream of signed 24-bit samples with a three-tap finite impulse response. Each accepted sample, together with the two samples accepted before it, is weighted by three programmable signed coefficients. The three weighted terms come from three separate radix-4 Booth multipliers that work in the same cycle. A row of 3:2 carry-save cells reduces the three products to a sum word and a carry word. A 48-bit grouped carry-lookahead adder then joins the two words into the filter output.

The sample history advances only on cycles that carry a valid sample. The registered 48-bit result appears one clock after its sample, with a matching valid strobe. Coefficients are written one tap at a time through a small write port.

Top module: `fir3_top`

## Requirements
- R1: A synchronous active-high reset clears out_valid, out_result, both history registers and all three coefficients. A sample accepted after reset with no coefficient written gives a result of 0, and history terms read as 0.
- R2: For an accepted sample x[n], out_result equals coef[0]*x[n] + coef[1]*x[n-1] + coef[2]*x[n-2], where x[n-1] and x[n-2] are the two previously accepted samples. All values are two's complement.
- R3: out_valid is high in exactly the cycle after a cycle with in_valid high, and low otherwise.
- R4: The history registers shift only when in_valid is high. Idle cycles leave x[n-1] and x[n-2] unchanged for the next accepted sample.
- R5: While in_valid is low, out_result keeps its last value.
- R6: When coef_we is high, coef_val is written to the tap chosen by coef_idx: 0 weights the current sample, 1 the previous one, 2 the one before that. The value 3 writes nothing.
- R7: The output is the exact sum truncated to its low 48 bits. Any carry out of bit 47 is discarded, so sums beyond the signed 48-bit range wrap.
- R8: Each tap's Booth multiplier gives the exact signed 48-bit product of its coefficient and its sample in the same cycle as the other two taps.
- R9: The carry-save row keeps the arithmetic sum: sum word plus carry word, with the carry word already shifted up one bit, equals the sum of the three products modulo 2^48.
- R10: The carry-lookahead adder output equals the modulo-2^48 sum of the sum word and the carry word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_idx | input | 2 | Tap chosen for the write (3 = none) |
| coef_val | input | 24 | Signed coefficient value |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 48 | Signed filter output |

## Verification
The arithmetic checks sample the combinational tap products, the carry-save words and the adder output on every clock. This relies on in_sample, coef_val and the coefficients holding known, non-X values outside reset. The bench holds every input at a defined level from time zero and changes inputs only on falling edges. The latency and shift properties relate in_valid to the registered state one edge later, so they assume that in_valid is driven to 0 or 1 on every cycle.

// File: rtl/fir3_pkg.sv
package fir3_pkg;

    localparam int DATA_W = 24;
    localparam int ACC_W  = 2 * DATA_W;
    localparam int NTAPS  = 3;
    localparam int IDX_W  = 2;

    typedef enum logic [IDX_W-1:0] {
        TAP_CUR   = 2'd0,
        TAP_PREV1 = 2'd1,
        TAP_PREV2 = 2'd2,
        TAP_NONE  = 2'd3
    } tap_sel_t;

    typedef logic signed [DATA_W-1:0] sample_t;
    typedef logic        [ACC_W-1:0]  wide_t;

    typedef struct packed {
        wide_t sum;
        wide_t carry;   // already weighted by 2 (shifted up one bit)
    } cs_pair_t;

    function automatic wide_t widen(input sample_t v);
        return {{(ACC_W-DATA_W){v[DATA_W-1]}}, v};
    endfunction

endpackage

// File: rtl/fir3_booth_mul.sv
module fir3_booth_mul #(
    parameter int AW = 24,
    parameter int PW = 2 * AW
) (
    input  logic [AW-1:0] mcand,
    input  logic [AW-1:0] mplier,
    output logic [PW-1:0] prod
);
    localparam int NDIG = AW / 2;

    logic [AW:0]   bx;
    logic [PW-1:0] ae;

    assign bx = {mplier, 1'b0};
    assign ae = {{(PW-AW){mcand[AW-1]}}, mcand};

    always_comb begin
        logic [PW-1:0] acc;
        logic [PW-1:0] pp;
        acc = '0;
        for (int i = 0; i < NDIG; i++) begin
            case (bx[2*i +: 3])
                3'b001, 3'b010: pp = ae;
                3'b011:         pp = ae << 1;
                3'b100:         pp = -(ae << 1);
                3'b101, 3'b110: pp = -ae;
                default:        pp = '0;
            endcase
            acc = acc + (pp << (2 * i));
        end
        prod = acc;
    end
endmodule

// File: rtl/fir3_csa.sv
module fir3_csa
    import fir3_pkg::*;
(
    input  wide_t    x0,
    input  wide_t    x1,
    input  wide_t    x2,
    output cs_pair_t res
);
    wide_t s;
    wide_t c;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < ACC_W; i++) begin : g_bit
        assign s[i] = x0[i] ^ x1[i] ^ x2[i];
        if (i < ACC_W - 1) begin : g_cy
            assign c[i+1] = (x0[i] & x1[i]) | (x0[i] & x2[i]) | (x1[i] & x2[i]);
        end
    end

    assign res.sum   = s;
    assign res.carry = c;
endmodule

// File: rtl/fir3_cla.sv
module fir3_cla #(
    parameter int W   = 48,
    parameter int GRP = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam int NG = W / GRP;

    logic [W-1:0]  g, p;
    logic [NG-1:0] bc;
    logic [NG-1:0] gg, gp;

    assign g = a & b;
    assign p = a ^ b;

    always_comb begin
        gg = '0;
        gp = '0;
        for (int k = 0; k < NG - 1; k++) begin
            logic bg, bp;
            bg = 1'b0;
            bp = 1'b1;
            for (int j = 0; j < GRP; j++) begin
                bg = g[k*GRP+j] | (p[k*GRP+j] & bg);
                bp = bp & p[k*GRP+j];
            end
            gg[k] = bg;
            gp[k] = bp;
        end
        bc = '0;
        for (int k = 1; k < NG; k++)
            bc[k] = gg[k-1] | (gp[k-1] & bc[k-1]);
    end

    always_comb begin
        s = '0;
        for (int k = 0; k < NG; k++) begin
            logic c;
            c = bc[k];
            for (int j = 0; j < GRP; j++) begin
                s[k*GRP+j] = p[k*GRP+j] ^ c;
                c = g[k*GRP+j] | (p[k*GRP+j] & c);
            end
        end
    end
endmodule

// File: rtl/fir3_top.sv
module fir3_top
    import fir3_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [DATA_W-1:0] coef_val,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_result
);
    sample_t  coef [NTAPS];
    sample_t  hist [NTAPS-1];
    sample_t  tap  [NTAPS];
    wide_t    prod [NTAPS];
    cs_pair_t cs;
    wide_t    total;
    tap_sel_t sel;

    assign sel    = tap_sel_t'(coef_idx);
    assign tap[0] = sample_t'(in_sample);

    for (genvar t = 1; t < NTAPS; t++) begin : g_tap
        assign tap[t] = hist[t-1];
    end

    for (genvar t = 0; t < NTAPS; t++) begin : g_mul
        fir3_booth_mul #(.AW(DATA_W), .PW(ACC_W)) u_mul (
            .mcand (coef[t]),
            .mplier(tap[t]),
            .prod  (prod[t])
        );
    end

    fir3_csa u_csa (
        .x0 (prod[0]),
        .x1 (prod[1]),
        .x2 (prod[2]),
        .res(cs)
    );

    fir3_cla #(.W(ACC_W), .GRP(4)) u_cla (
        .a(cs.sum),
        .b(cs.carry),
        .s(total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NTAPS; t++) coef[t] <= '0;
            for (int t = 0; t < NTAPS - 1; t++) hist[t] <= '0;
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            if (coef_we) begin
                case (sel)
                    TAP_CUR:   coef[0] <= sample_t'(coef_val);
                    TAP_PREV1: coef[1] <= sample_t'(coef_val);
                    TAP_PREV2: coef[2] <= sample_t'(coef_val);
                    default:   ;
                endcase
            end
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= total;
                hist[0]    <= tap[0];
                for (int t = 1; t < NTAPS - 1; t++) hist[t] <= hist[t-1];
            end
        end
    end

    // R3
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(hist[0]) && $stable(hist[1])));
    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (hist[0] == $past(tap[0]) && hist[1] == $past(hist[0])));
    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_result));
    // R8
    tap_product_chk: assert property (@(posedge clk) disable iff (rst)
        prod[0] == wide_t'($signed(widen(coef[0])) * $signed(widen(tap[0]))) &&
        prod[1] == wide_t'($signed(widen(coef[1])) * $signed(widen(tap[1]))) &&
        prod[2] == wide_t'($signed(widen(coef[2])) * $signed(widen(tap[2]))));
    // R9
    csa_sum_chk: assert property (@(posedge clk) disable iff (rst)
        wide_t'(cs.sum + cs.carry) == wide_t'(prod[0] + prod[1] + prod[2]));
    // R10
    cla_sum_chk: assert property (@(posedge clk) disable iff (rst)
        total == wide_t'(cs.sum + cs.carry));
endmodule

// File: tb/fir3_top_test.sv
module fir3_top_test;
    import fir3_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_sample = '0;
    logic              coef_we = 1'b0;
    logic [IDX_W-1:0]  coef_idx = '0;
    logic [DATA_W-1:0] coef_val = '0;
    logic              out_valid;
    logic [ACC_W-1:0]  out_result;

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    longint mc [3];
    longint mh1, mh2;
    logic [ACC_W-1:0] last_exp;

    always #2.5 clk = ~clk;

    fir3_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_val(coef_val),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [DATA_W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; coef_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        mc[0] = 0; mc[1] = 0; mc[2] = 0; mh1 = 0; mh2 = 0;
        last_exp = '0;
    endtask

    task automatic load(input logic [1:0] idx, input logic [DATA_W-1:0] v);
        @(negedge clk);
        coef_we = 1'b1; coef_idx = idx; coef_val = v;
        @(negedge clk);
        coef_we = 1'b0;
        if (idx != 2'd3) mc[idx] = sx(v);
    endtask

    task automatic push(input string req, input logic [DATA_W-1:0] x);
        longint e;
        @(negedge clk);
        in_valid = 1'b1; in_sample = x;
        e = mc[0] * sx(x) + mc[1] * mh1 + mc[2] * mh2;
        last_exp = e[ACC_W-1:0];
        mh2 = mh1; mh1 = sx(x);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " value"}, 64'(out_result), 64'(last_exp));
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 valid low", 64'(out_valid), 64'd0);
        check("R1 result zero", 64'(out_result), 64'd0);
        push("R1 coef zero", 24'd1234);
        load(2'd0, 24'd1); load(2'd1, 24'd1); load(2'd2, 24'd1);
        do_reset();
        load(2'd0, 24'd7); load(2'd1, 24'd11); load(2'd2, 24'd13);
        push("R1 history zero", 24'd100);
        push("R1 history one", 24'd3);
    endtask

    task automatic t_basic();
        do_reset();
        load(2'd0, 24'd3); load(2'd1, -24'sd2); load(2'd2, 24'd5);
        push("R2 a", 24'd10);
        push("R2 b", -24'sd4);
        push("R2 c", 24'd1000);
        push("R6 order", 24'd0);
        push("R2 d", -24'sd77);
    endtask

    task automatic t_idle();
        do_reset();
        load(2'd0, 24'd2); load(2'd1, 24'd9); load(2'd2, -24'sd6);
        push("R2 idle pre1", 24'd50);
        push("R2 idle pre2", 24'd60);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R3 no strobe", 64'(out_valid), 64'd0);
            check("R5 hold", 64'(out_result), 64'(last_exp));
        end
        push("R4 no shift on idle", 24'd70);
    endtask

    task automatic t_sel3();
        do_reset();
        load(2'd0, 24'd4); load(2'd1, 24'd5); load(2'd2, 24'd6);
        load(2'd3, 24'd999);
        push("R6 idx3 a", 24'd1);
        push("R6 idx3 b", 24'd2);
        push("R6 idx3 c", 24'd3);
    endtask

    task automatic t_extreme();
        do_reset();
        load(2'd0, 24'h800000); load(2'd1, 24'h800000); load(2'd2, 24'h800000);
        push("R8 min sq", 24'h800000);
        push("R10 min sum", 24'h800000);
        push("R7 wrap", 24'h800000);
        push("R8 mixed", 24'h7FFFFF);
        load(2'd1, 24'h7FFFFF);
        push("R7 R10 mixed", 24'hFFFFFF);
    endtask

    task automatic t_stream();
        logic [23:0] lf = 24'h5A1C3E;
        do_reset();
        load(2'd0, 24'h12345); load(2'd1, 24'hF00F00); load(2'd2, 24'h7ABCDE);
        for (int i = 0; i < 20; i++) begin
            lf = {lf[22:0], lf[23] ^ lf[22] ^ lf[21] ^ lf[16]};
            push("R9 R2 pattern", lf);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_idle();
        t_sel3();
        t_extreme();
        t_stream();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule